// File: doc/BRIEF.md
# Priority Vector Interrupt Aggregator

This block gathers up to sixteen event strobes from capture/compare channels into a pending register. A mask register selects which of those pending flags may raise the single shared interrupt line. Software reaches both registers through a small word-wide register port. A third read-only location, the priority vector, returns a code that names the most urgent unmasked pending source. Reading the vector acknowledges the source: the read clears that source's pending flag at the following clock edge. An interrupt handler therefore loops: it reads the vector, services the channel the vector names, and stops once the vector reads zero.

Priority is fixed. Source 0 is the most urgent, and the code returned is the source index plus one. A code of zero means no unmasked source is pending. Some source positions are reserved. Their pending and mask bits are held at zero whatever is written to them and whatever events arrive on them.

The shared request is kept by a two-state machine:
- `ST_QUIET`: no request.
- `ST_RAISED`: request asserted.
- Transition `raise` (`ST_QUIET` to `ST_RAISED`) is taken at a clock edge when any pending flag is set whose mask bit is also set.
- Transition `drop` (`ST_RAISED` to `ST_QUIET`) is taken at a clock edge when no such flag remains.
- In all other cases each state holds.

Top module: `prio_vec_irq`

## Requirements
- R1: After reset the pending register and the mask register both read 0, the vector reads 0, and `irq_o` is low.
- R2: A high bit on `evt_i` sets the matching pending bit at the next clock edge. This happens whether or not the bit is masked.
- R3: A register write to address 0 loads the pending register from `reg_wdata_i`, setting and clearing bits. An event on a bit in the same cycle as the write leaves that bit set.
- R4: Bits 2, 3, 4, 5, 14 and 15 are reserved. In both the pending and the mask register they always read 0, whatever is written and whatever events arrive.
- R5: With `reg_addr_i` = 2, `reg_rdata_o[4:0]` holds 1 + the lowest index whose pending and mask bits are both 1, or 0 when there is none. Bits 15:5 read 0.
- R6: A read strobe at address 2 with a non-zero vector clears that one pending bit at the next edge and leaves every other bit unchanged. A read strobe with a zero vector changes nothing.
- R7: An event on the bit being acknowledged, in the same cycle as the acknowledging vector read, leaves that bit set.
- R8: `irq_o` goes high one clock after the registers first hold an unmasked pending bit. It goes low one clock after none remains.
- R9: A pending bit whose mask bit is 0 stays pending but affects neither the vector code nor `irq_o`.

Register map (`reg_addr_i`):
- 0: pending register, read/write.
- 1: mask register, read/write.
- 2: priority vector, read only.
- 3: reads 0.

`reg_rdata_o` always shows the addressed register, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| evt_i | input | 16 | One strobe per source; a high bit marks that source pending |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_rd_i | input | 1 | Read strobe; at address 2 it acknowledges the winning source |
| reg_addr_i | input | 2 | Register select: 0 pending, 1 mask, 2 vector |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the addressed register |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench goes after the cases where two actions hit the same bit in one cycle:
- An event together with an acknowledging read. A design that let the clear win would lose an event (R7).
- An event together with a software write of 0. A design that let the write win would also drop the event (R3).

Priority ordering is probed with several flags pending at once, under partial masks. An encoder that ignored the mask, or scanned from the wrong end, would return the wrong code and acknowledge the wrong channel (R5, R9). Reserved positions are written and struck by events. A design that let them set would raise a request that no vector read can ever clear. The bench also tracks the request line across the last acknowledge. A line that dropped early, or lingered, would lose or repeat interrupts (R8).

// File: rtl/piv_pkg.sv
package piv_pkg;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_state_e;

    localparam logic [1:0] ADDR_PEND = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_VEC  = 2'd2;

endpackage

// File: rtl/piv_pending.sv
module piv_pending #(
    parameter int                 NUM_SRC   = 16,
    parameter logic [NUM_SRC-1:0] RSVD_BITS = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               pend_wr_i,
    input  logic               mask_wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] mask_o
);

    logic [NUM_SRC-1:0] pend_q, pend_d;
    logic [NUM_SRC-1:0] mask_q, mask_d;

    always_comb begin
        // Software load and acknowledge first; events are ORed last so they always win
        pend_d = pend_wr_i ? wdata_i : (pend_q & ~ack_i);
        pend_d = (pend_d | evt_i) & ~RSVD_BITS;
        mask_d = mask_wr_i ? (wdata_i & ~RSVD_BITS) : mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= pend_d;
            mask_q <= mask_d;
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/piv_encoder.sv
module piv_encoder #(
    parameter int NUM_SRC = 16,
    parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] win_o,
    output logic [VEC_W-1:0]   code_o
);

    // blocked[i] is set when any lower-numbered source requests
    logic [NUM_SRC:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign blocked[g+1] = blocked[g] | req_i[g];
        assign win_o[g]     = req_i[g] & ~blocked[g];
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (win_o[i]) code_o = code_o | VEC_W'(i + 1);
        end
    end

endmodule

// File: rtl/piv_irq_fsm.sv
module piv_irq_fsm
    import piv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_live_i,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (any_live_i)  state_d = ST_RAISED;  // raise
            ST_RAISED: if (!any_live_i) state_d = ST_QUIET;   // drop
            default:                    state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_RAISED);
    end

endmodule

// File: rtl/prio_vec_irq.sv
module prio_vec_irq
    import piv_pkg::*;
#(
    parameter int                 NUM_SRC   = 16,
    parameter logic [NUM_SRC-1:0] RSVD_BITS = 16'hC03C,
    parameter int                 VEC_W     = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic [NUM_SRC-1:0] reg_rdata_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] pend_q, mask_q, live, win, ack;
    logic [VEC_W-1:0]   code;
    logic               vec_rd;

    assign live   = pend_q & mask_q;
    assign vec_rd = reg_rd_i && (reg_addr_i == ADDR_VEC);
    assign ack    = vec_rd ? win : '0;

    piv_pending #(.NUM_SRC(NUM_SRC), .RSVD_BITS(RSVD_BITS)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .pend_wr_i (reg_wr_i && (reg_addr_i == ADDR_PEND)),
        .mask_wr_i (reg_wr_i && (reg_addr_i == ADDR_MASK)),
        .wdata_i   (reg_wdata_i),
        .ack_i     (ack),
        .pend_o    (pend_q),
        .mask_o    (mask_q)
    );

    piv_encoder #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_enc (
        .req_i  (live),
        .win_o  (win),
        .code_o (code)
    );

    piv_irq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_live_i (|live),
        .irq_o      (irq_o)
    );

    always_comb begin
        unique case (reg_addr_i)
            ADDR_PEND: reg_rdata_o = pend_q;
            ADDR_MASK: reg_rdata_o = mask_q;
            ADDR_VEC:  reg_rdata_o = NUM_SRC'(code);
            default:   reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/piv_checker.sv
module piv_checker #(
    parameter int                 NUM_SRC   = 16,
    parameter logic [NUM_SRC-1:0] RSVD_BITS = 16'hC03C
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               reg_rd_i,
    input logic [1:0]         reg_addr_i,
    input logic [NUM_SRC-1:0] reg_rdata_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] mask_q
);

    logic [NUM_SRC-1:0] real_evt;
    logic [NUM_SRC-1:0] ack_bit;
    logic               vec_sel;

    assign real_evt = evt_i & ~RSVD_BITS;
    assign vec_sel  = (reg_addr_i == 2'd2);
    assign ack_bit  = (vec_sel && reg_rdata_o[4:0] != 5'd0) ?
                      (NUM_SRC'(1) << (reg_rdata_o[4:0] - 5'd1)) : '0;

    p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q | mask_q) & RSVD_BITS) == '0);

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (real_evt != '0) |=> ((pend_q & $past(real_evt)) == $past(real_evt)));

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & mask_q) != '0) |=> irq_o);

    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & mask_q) == '0) |=> !irq_o);

    p_vec_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_sel |-> (reg_rdata_o[NUM_SRC-1:5] == '0));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && ack_bit != '0 && (ack_bit & evt_i) == '0)
        |=> ((pend_q & $past(ack_bit)) == '0));

    p_ack_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && ack_bit != '0 && (ack_bit & evt_i) != '0)
        |=> ((pend_q & $past(ack_bit)) != '0));

endmodule

bind prio_vec_irq piv_checker #(.NUM_SRC(NUM_SRC), .RSVD_BITS(RSVD_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .pend_q      (pend_q),
    .mask_q      (mask_q)
);

// File: tb/sim_prio_vec_irq.sv
module sim_prio_vec_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_i = '0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [15:0] m_pend = '0;
    logic [15:0] m_mask = '0;
    logic        m_irq  = 1'b0;
    localparam logic [15:0] RSV = 16'b1100_0000_0011_1100;

    always #4 clk = ~clk;

    prio_vec_irq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .reg_wr_i    (reg_wr_i),
        .reg_rd_i    (reg_rd_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    function automatic int model_vec();
        for (int i = 0; i < 16; i++)
            if (m_pend[i] && m_mask[i]) return i + 1;
        return 0;
    endfunction

    function automatic logic [15:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_pend;
            2'd1:    return m_mask;
            2'd2:    return 16'(model_vec());
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // One clock: drive at negedge, check read data, update model at edge, check irq
    task automatic step(input string req, input logic [15:0] evt, input logic wr,
                        input logic rd, input logic [1:0] addr, input logic [15:0] wd);
        logic [15:0] nxt_pend;
        logic [15:0] nxt_mask;
        logic        nxt_irq;
        int          v;
        evt_i = evt; reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = addr; reg_wdata_i = wd;
        #1;
        check(req, "read data", reg_rdata_o, model_read(addr));
        nxt_pend = m_pend;
        nxt_mask = m_mask;
        nxt_irq  = (m_pend & m_mask) != 16'h0;
        if (wr && addr == 2'd0) nxt_pend = wd;
        if (wr && addr == 2'd1) nxt_mask = wd & ~RSV;
        v = model_vec();
        if (rd && addr == 2'd2 && v != 0) nxt_pend[v-1] = 1'b0;
        nxt_pend = (nxt_pend | evt) & ~RSV;
        @(posedge clk);
        m_pend = nxt_pend;
        m_mask = nxt_mask;
        m_irq  = nxt_irq;
        @(negedge clk);
        check("R8", "irq_o", {15'h0, irq_o}, {15'h0, m_irq});
        evt_i = '0; reg_wr_i = 1'b0; reg_rd_i = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL R8 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step("R1", 16'h0, 0, 0, 2'd0, 16'h0);
        step("R1", 16'h0, 0, 0, 2'd1, 16'h0);
        step("R1", 16'h0, 0, 0, 2'd2, 16'h0);
        // R6 empty vector read changes nothing
        step("R6", 16'h0, 0, 1, 2'd2, 16'h0);
        // R2 R9 masked event records pending but no irq, no vector
        step("R2", 16'h0080, 0, 0, 2'd0, 16'h0);
        step("R9", 16'h0, 0, 0, 2'd0, 16'h0);
        step("R9", 16'h0, 0, 1, 2'd2, 16'h0);
        step("R9", 16'h0, 0, 0, 2'd0, 16'h0);
        // R4 mask reserved bits stay zero
        step("R4", 16'h0, 1, 0, 2'd1, 16'hFFFF);
        step("R4", 16'h0, 0, 0, 2'd1, 16'h0);
        // R8 irq rises, R5 vector 8, R6 ack clears, irq drops
        step("R5", 16'h0, 0, 0, 2'd2, 16'h0);
        step("R6", 16'h0, 0, 1, 2'd2, 16'h0);
        step("R6", 16'h0, 0, 0, 2'd0, 16'h0);
        step("R8", 16'h0, 0, 0, 2'd2, 16'h0);
        // R4 events on reserved positions are ignored
        step("R4", 16'h803C, 0, 0, 2'd0, 16'h0);
        step("R4", 16'h0, 0, 0, 2'd0, 16'h0);
        step("R8", 16'h0, 0, 0, 2'd2, 16'h0);
        // R5 priority among several sources, acked in order
        step("R2", 16'h4301, 0, 0, 2'd0, 16'h0);
        for (int k = 0; k < 5; k++) step("R5", 16'h0, 0, 1, 2'd2, 16'h0);
        step("R6", 16'h0, 0, 0, 2'd0, 16'h0);
        // R7 event on the bit being acked keeps it set
        step("R7", 16'h0002, 0, 0, 2'd2, 16'h0);
        step("R7", 16'h0002, 0, 1, 2'd2, 16'h0);
        step("R7", 16'h0, 0, 0, 2'd0, 16'h0);
        step("R7", 16'h0, 0, 1, 2'd2, 16'h0);
        step("R7", 16'h0, 0, 0, 2'd0, 16'h0);
        // R3 software set and clear, event beats write of zero
        step("R3", 16'h0, 1, 0, 2'd0, 16'h03C3);
        step("R3", 16'h0, 0, 0, 2'd0, 16'h0);
        step("R3", 16'h0040, 1, 0, 2'd0, 16'h0);
        step("R3", 16'h0, 0, 0, 2'd0, 16'h0);
        // R9 partial mask picks a higher index over masked lower ones
        step("R9", 16'h0, 1, 0, 2'd1, 16'h0200);
        step("R9", 16'h0203, 0, 0, 2'd2, 16'h0);
        step("R9", 16'h0, 0, 1, 2'd2, 16'h0);
        step("R9", 16'h0, 0, 0, 2'd0, 16'h0);
        step("R8", 16'h0, 0, 0, 2'd2, 16'h0);
        // R3 software clear of all pending
        step("R3", 16'h0, 1, 0, 2'd0, 16'h0);
        step("R3", 16'h0, 0, 0, 2'd0, 16'h0);
        // R1 reset again mid-run
        rst_n = 1'b0;
        @(posedge clk);
        m_pend = '0; m_mask = '0; m_irq = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 16'h0, 0, 0, 2'd1, 16'h0);
        step("R1", 16'h0, 0, 0, 2'd0, 16'h0);
        summary();
        $finish;
    end

endmodule